// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Round-Half-to-Even

This block performs one step of fractional multiply-accumulate. Two signed 16-bit operands in 1.15 format are multiplied. The product is moved into the 36-bit accumulator format, which has four guard bits above a 16-bit upper word and a 16-bit lower word. The product is then added to or subtracted from the caller's accumulator value. The sum is rounded onto the upper word with round-half-to-even, and the lower word is cleared.

The result is registered. It appears one clock after a valid input, together with a matching valid strobe. A mode input can block subtraction for contexts where only accumulation is allowed. The datapath applies no saturation, so a result that leaves the 36-bit range wraps.

Top module: `fmac_conv_round`

## Requirements
- R1: The product contribution is the signed product of `op_a` and `op_b`, doubled (shifted left one place) and sign-extended to 36 bits. For example, 0x8000 × 0x8000 contributes +0x0_8000_0000.
- R2: With `neg_prod` low, the pre-round sum is `acc_in` plus the product contribution, taken modulo 2^36.
- R3: With `neg_prod` high and `add_only` low, the pre-round sum is `acc_in` minus the product contribution. For example, 0x4000 and 0xC000 subtracted from 0x0_0003_8000 give 0x0_2004_0000.
- R4: With `add_only` high, the block always adds, whatever the level of `neg_prod`.
- R5: If bits 15:0 of the sum are above 0x8000, bits 35:16 are incremented by one. If those bits are below 0x8000, bits 35:16 are kept unchanged.
- R6: If bits 15:0 of the sum equal exactly 0x8000, bits 35:16 are incremented only when bit 16 is 1, so the rounded bit 16 is always 0.
- R7: Bits 15:0 of every result written to `acc_out` are zero.
- R8: The rounding increment carries through the guard bits, and the whole result wraps modulo 2^36 with no saturation. For example, 0x7_FFFF_8000 + 0 gives 0x8_0000_0000.
- R9: `acc_out` and `out_vld` update on the clock edge that samples `in_vld` high. `out_vld` is high exactly in the cycle after each valid input. `acc_out` holds its value when `in_vld` is low.
- R10: A synchronous active-high `rst` clears `acc_out` to zero and `out_vld` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and accumulator are valid this cycle |
| op_a | input | 16 | First multiplier operand, signed 1.15 |
| op_b | input | 16 | Second multiplier operand, signed 1.15 |
| acc_in | input | 36 | Current accumulator value (4 guard, 16 upper, 16 lower bits) |
| neg_prod | input | 1 | 1 = subtract the product, 0 = add it |
| add_only | input | 1 | 1 = force addition regardless of neg_prod |
| acc_out | output | 36 | Rounded accumulator result |
| out_vld | output | 1 | acc_out was updated by the previous valid input |

## Verification
The assertions check the following on every cycle:
- The rounding never moves the upper part by more than one.
- A lower word below the half point leaves the upper part untouched.
- A tie produces an even upper word.
- Forced-add mode feeds a plain sum.
- The valid strobe and the hold behaviour follow the timing rule.

The arithmetic value itself (product alignment, sign direction, wrap through the guard bits) is shown only by the bench. It sweeps a grid of operand pairs against an independent wide-integer model and then runs directed ties, the -1 × -1 corner, negative accumulators and the wrap case.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
   typedef enum logic [0:0] {
      MUL_NATIVE    = 1'b0,
      MUL_SHIFT_ADD = 1'b1
   } mul_style_e;

   localparam int unsigned FMAC_OP_W_DEF    = 16;
   localparam int unsigned FMAC_GUARD_W_DEF = 4;
endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
   parameter int unsigned            OP_W      = 16,
   parameter int unsigned            ACC_W     = 36,
   parameter fmac_pkg::mul_style_e   MUL_STYLE = fmac_pkg::MUL_NATIVE
) (
   input  logic [OP_W-1:0]  mul_a,
   input  logic [OP_W-1:0]  mul_b,
   output logic [ACC_W-1:0] prod_aligned
);
   localparam int unsigned PROD_W = 2 * OP_W;
   localparam int unsigned EXT_W  = ACC_W - PROD_W;

   logic signed [PROD_W-1:0] raw_prod;
   logic signed [ACC_W-1:0]  prod_ext;

   generate
      if (ACC_W <= PROD_W) begin : g_bad_width
         $error("fmac_mult: accumulator needs at least one guard bit");
      end

      if (MUL_STYLE == fmac_pkg::MUL_NATIVE) begin : g_native
         assign raw_prod = $signed(mul_a) * $signed(mul_b);
      end else begin : g_shift_add
         logic signed [PROD_W-1:0] a_wide;
         logic signed [PROD_W-1:0] pp_sum;
         assign a_wide = {{OP_W{mul_a[OP_W-1]}}, mul_a};
         always_comb begin
            pp_sum = '0;
            for (int i = 0; i < int'(OP_W) - 1; i++) begin
               if (mul_b[i]) pp_sum = pp_sum + (a_wide <<< i);
            end
            if (mul_b[OP_W-1]) pp_sum = pp_sum - (a_wide <<< (OP_W - 1));
         end
         assign raw_prod = pp_sum;
      end
   endgenerate

   // sign-extend first, then shift, so the -1 x -1 product stays positive
   assign prod_ext     = {{EXT_W{raw_prod[PROD_W-1]}}, raw_prod};
   assign prod_aligned = prod_ext <<< 1;
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum #(
   parameter int unsigned ACC_W = 36
) (
   input  logic [ACC_W-1:0] acc_val,
   input  logic [ACC_W-1:0] prod_val,
   input  logic             do_sub,
   output logic [ACC_W-1:0] sum_val
);
   logic [ACC_W-1:0] addend;
   logic             carry_in;

   // subtraction as add of the inverted operand plus one
   assign addend   = do_sub ? ~prod_val : prod_val;
   assign carry_in = do_sub;
   assign sum_val  = acc_val + addend + ACC_W'(carry_in);
endmodule

// File: rtl/fmac_round.sv
module fmac_round #(
   parameter int unsigned ACC_W = 36,
   parameter int unsigned LO_W  = 16
) (
   input  logic [ACC_W-1:0] pre_round,
   output logic [ACC_W-1:0] rounded
);
   localparam int unsigned HI_W = ACC_W - LO_W;
   localparam logic [LO_W-1:0] HALF = {1'b1, {(LO_W-1){1'b0}}};

   logic [LO_W-1:0] low_part;
   logic [HI_W-1:0] high_part;
   logic            above_half;
   logic            at_half;
   logic            bump;

   generate
      if (LO_W < 2 || HI_W < 1) begin : g_bad_split
         $error("fmac_round: invalid word split");
      end
   endgenerate

   assign low_part   = pre_round[LO_W-1:0];
   assign high_part  = pre_round[ACC_W-1:LO_W];
   assign above_half = low_part > HALF;
   assign at_half    = low_part == HALF;
   assign bump       = above_half | (at_half & high_part[0]);
   assign rounded    = {high_part + HI_W'(bump), {LO_W{1'b0}}};
endmodule

// File: rtl/fmac_conv_round.sv
module fmac_conv_round #(
   parameter int unsigned          OP_W      = fmac_pkg::FMAC_OP_W_DEF,
   parameter int unsigned          GUARD_W   = fmac_pkg::FMAC_GUARD_W_DEF,
   parameter fmac_pkg::mul_style_e MUL_STYLE = fmac_pkg::MUL_NATIVE
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_vld,
   input  logic [OP_W-1:0]               op_a,
   input  logic [OP_W-1:0]               op_b,
   input  logic [GUARD_W+2*OP_W-1:0]     acc_in,
   input  logic                          neg_prod,
   input  logic                          add_only,
   output logic [GUARD_W+2*OP_W-1:0]     acc_out,
   output logic                          out_vld
);
   localparam int unsigned ACC_W = GUARD_W + 2 * OP_W;
   localparam int unsigned LO_W  = OP_W;
   localparam int unsigned HI_W  = ACC_W - LO_W;
   localparam logic [LO_W-1:0] HALF = {1'b1, {(LO_W-1){1'b0}}};

   generate
      if (OP_W < 2) begin : g_bad_op
         $error("fmac_conv_round: OP_W must be at least 2");
      end
      if (GUARD_W < 1) begin : g_bad_guard
         $error("fmac_conv_round: GUARD_W must be at least 1");
      end
   endgenerate

   logic [ACC_W-1:0] prod_w;
   logic [ACC_W-1:0] sum_w;
   logic [ACC_W-1:0] rnd_w;
   logic             sub_sel;
   logic [ACC_W-1:0] acc_q;
   logic             vld_q;

   assign sub_sel = neg_prod & ~add_only;

   fmac_mult #(.OP_W(OP_W), .ACC_W(ACC_W), .MUL_STYLE(MUL_STYLE)) u_mult (
      .mul_a        (op_a),
      .mul_b        (op_b),
      .prod_aligned (prod_w)
   );

   fmac_accum #(.ACC_W(ACC_W)) u_accum (
      .acc_val  (acc_in),
      .prod_val (prod_w),
      .do_sub   (sub_sel),
      .sum_val  (sum_w)
   );

   fmac_round #(.ACC_W(ACC_W), .LO_W(LO_W)) u_round (
      .pre_round (sum_w),
      .rounded   (rnd_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) acc_q <= rnd_w;
      end
   end

   assign acc_out = acc_q;
   assign out_vld = vld_q;

   assert_add_only_R4: assert property (@(posedge clk) disable iff (rst)
      (in_vld && add_only) |-> (sum_w == acc_in + prod_w));

   assert_incr_bound_R5: assert property (@(posedge clk) disable iff (rst)
      in_vld |-> ((rnd_w[ACC_W-1:LO_W] - sum_w[ACC_W-1:LO_W]) <= HI_W'(1)));

   assert_below_half_R5: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (sum_w[LO_W-1:0] < HALF)) |-> (rnd_w[ACC_W-1:LO_W] == sum_w[ACC_W-1:LO_W]));

   assert_tie_even_R6: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (sum_w[LO_W-1:0] == HALF)) |-> (rnd_w[LO_W] == 1'b0));

   assert_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> (acc_out[LO_W-1:0] == '0));

   assert_vld_follow_R9: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   assert_vld_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(acc_out));
endmodule

// File: tb/fmac_conv_round_tb.sv
module fmac_conv_round_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [15:0] op_a;
   logic [15:0] op_b;
   logic [35:0] acc_in;
   logic        neg_prod;
   logic        add_only;
   logic [35:0] acc_out;
   logic        out_vld;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   fmac_conv_round u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
      .acc_in(acc_in), .neg_prod(neg_prod), .add_only(add_only),
      .acc_out(acc_out), .out_vld(out_vld)
   );

   function automatic logic [35:0] model(logic [15:0] a, logic [15:0] b,
                                         logic [35:0] acc, logic neg, logic ao);
      longint      p;
      longint      s;
      logic [63:0] t;
      logic [15:0] lo;
      logic [19:0] hi;
      p = longint'($signed(a)) * longint'($signed(b)) * 2;
      s = longint'($signed(acc));
      s = (neg && !ao) ? s - p : s + p;
      t = s;
      lo = t[15:0];
      hi = t[35:16];
      if (lo > 16'h8000 || (lo == 16'h8000 && hi[0])) hi = hi + 20'd1;
      return {hi, 16'h0000};
   endfunction

   task automatic check36(string req, logic [35:0] got, logic [35:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic check1(string req, logic got, logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic run_op(string req, logic [15:0] a, logic [15:0] b,
                         logic [35:0] acc, logic neg, logic ao);
      op_a = a; op_b = b; acc_in = acc; neg_prod = neg; add_only = ao;
      in_vld = 1'b1;
      @(negedge clk);
      check36(req, acc_out, model(a, b, acc, neg, ao));
      check1({req, " R9 strobe"}, out_vld, 1'b1);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [35:0] held;
      rst = 1'b1; in_vld = 1'b0; op_a = '0; op_b = '0; acc_in = '0;
      neg_prod = 1'b0; add_only = 1'b0;
      repeat (3) @(negedge clk);
      check36("R10 reset acc", acc_out, 36'h0);
      check1("R10 reset vld", out_vld, 1'b0);
      rst = 1'b0;
      @(negedge clk);

      // R3 R6: documented subtract case, tie on odd upper word
      run_op("R3 R6 subtract example", 16'h4000, 16'hC000, 36'h0_0003_8000, 1'b1, 1'b0);
      check36("R3 exact value", acc_out, 36'h0_2004_0000);
      // R6: tie on even upper word stays
      run_op("R6 tie even", 16'h0000, 16'h1234, 36'h0_0002_8000, 1'b0, 1'b0);
      check36("R6 tie even value", acc_out, 36'h0_0002_0000);
      run_op("R6 tie odd", 16'h0000, 16'h1234, 36'h0_0005_8000, 1'b0, 1'b0);
      check36("R6 tie odd value", acc_out, 36'h0_0006_0000);
      // R5: above and below half
      run_op("R5 above half", 16'h0000, 16'h0000, 36'h0_0004_8001, 1'b0, 1'b0);
      check36("R5 above value", acc_out, 36'h0_0005_0000);
      run_op("R5 below half", 16'h0000, 16'h0000, 36'h0_0004_7FFF, 1'b0, 1'b0);
      check36("R5 below value", acc_out, 36'h0_0004_0000);
      // R1: -1 x -1
      run_op("R1 minus one squared", 16'h8000, 16'h8000, 36'h0, 1'b0, 1'b0);
      check36("R1 value", acc_out, 36'h0_8000_0000);
      // R2: negative accumulator
      run_op("R2 negative acc", 16'h2000, 16'h2000, 36'hF_C000_0000, 1'b0, 1'b0);
      check36("R2 value", acc_out, 36'hF_C800_0000);
      // R4: forced add with negate requested
      run_op("R4 add only", 16'h4000, 16'hC000, 36'h0_0003_8000, 1'b1, 1'b1);
      check36("R4 value", acc_out, 36'hF_E004_0000);
      // R8: increment through guard bits, and wrap at the top
      run_op("R8 guard carry", 16'h0000, 16'h0000, 36'h7_FFFF_8000, 1'b0, 1'b0);
      check36("R8 guard value", acc_out, 36'h8_0000_0000);
      run_op("R8 wrap", 16'h0000, 16'h0000, 36'hF_FFFF_C000, 1'b0, 1'b0);
      check36("R8 wrap value", acc_out, 36'h0_0000_0000);

      // R9: hold while idle
      held = acc_out;
      in_vld = 1'b0;
      op_a = 16'h7FFF; op_b = 16'h7FFF; acc_in = 36'h1_2345_6789;
      @(negedge clk);
      check36("R9 hold value", acc_out, held);
      check1("R9 idle strobe", out_vld, 1'b0);

      // R1 R2 R3 R4 R5 R6 R7: operand grid sweep against the model
      for (int ia = 0; ia < 64; ia++) begin
         for (int ib = 0; ib < 64; ib++) begin
            logic [15:0] a;
            logic [15:0] b;
            logic [35:0] acc;
            logic [31:0] r;
            a = 16'(ia * 1040 + 32768);
            b = 16'(ib * 1031 + 32768);
            r = $urandom;
            acc = {r[3:0], $urandom()};
            if (r[4]) acc[15:0] = 16'h8000;
            run_op("R2 R3 R4 R5 R6 sweep", a, b, acc, r[5], r[6] & r[7]);
            total++;
            if (acc_out[15:0] !== 16'h0) begin
               bad++;
               $display("FAIL R7: got %h expected 0000", acc_out[15:0]);
            end
         end
      end

      // R10: reset mid-stream
      in_vld = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check36("R10 reset again acc", acc_out, 36'h0);
      check1("R10 reset again vld", out_vld, 1'b0);
      rst = 1'b0;
      in_vld = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule